// File: doc/BRIEF.md
# Divided-Clock Word Serializer

This block turns parallel words into a serial bit stream on a single fast clock. It divides the fast clock by the word width to produce a slow clock. The slow clock goes out to the logic that supplies the words, so the two clocks stay phase aligned. Logic in the fast domain samples the slow clock and finds each of its rising edges. For each edge it captures the presented word into a holding register one fast cycle later. One cycle after that, a single-cycle load moves the word into a shift register. The shift register sends it most significant bit first, one bit per fast cycle.

The word source is expected to launch a new word on every rising edge of the slow clock. The block has no valid/ready handshake and applies no back-pressure. A word is taken once in every slow period whether the source changed it or not, and the source may not stall the stream. Words leave with no idle bits between them. A word-start pulse marks the first bit of each word.

Top module: `gearbox_serializer`

## Requirements
- R1: `slow_clk` has a period of exactly `WORD_W` fast cycles. It is high for `WORD_W/2` (rounded down) of them.
- R2: After synchronous reset is released, `slow_clk` rises on the first fast clock edge.
- R3: Each rising edge of `slow_clk` produces exactly one word on the serial output. `word_start` therefore pulses once per `WORD_W` fast cycles.
- R4: The first bit of a word appears on `ser_out` two fast cycles after the `slow_clk` rising edge that presented it. It is first sampled after the second fast edge following that rise.
- R5: A word is sent most significant bit first, one bit per fast cycle. Bit `WORD_W-1-b` is on `ser_out` in the b-th cycle of the word.
- R6: `word_start` is high for exactly the one cycle in which the most significant bit of a word is on `ser_out`, and low at all other times.
- R7: Consecutive words follow each other with no idle cycles. The MSB of word i+1 comes directly after the LSB of word i.
- R8: `par_data` is sampled only at the first fast edge after a `slow_clk` rise. A change of `par_data` after that edge has no effect on the word being sent.
- R9: While `rst` is high, `ser_out`, `word_start` and `slow_clk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock |
| rst | input | 1 | Synchronous reset, active high |
| par_data | input | WORD_W | Parallel word, launched on each `slow_clk` rising edge |
| slow_clk | output | 1 | Fast clock divided by `WORD_W`, supplied to the word source |
| ser_out | output | 1 | Serial data, MSB first |
| word_start | output | 1 | High with the first bit of each word |

## Verification
The stream is driven with alternating 0xAA/0x55 words, with all-ones, all-zero and walking-one words, and with a counting sequence. Alternating bits expose bit-order and one-bit slip errors. Solid words next to single set bits show whether a neighbouring word leaks across a word boundary. The counting sequence catches a word being repeated or skipped. A separate run changes `par_data` between the capture edge and the load edge. This separates a design that loads through the holding register from one that loads the live input.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/gbx_clk_div.sv
module gbx_clk_div #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  output logic slow_clk
);
  localparam int CW = gbx_pkg::cnt_bits(N);
  localparam int HALF = N / 2;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic slow_q;

  always_comb cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  // Reset parks the counter at the wrap point so the first edge after reset is a rise.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= LAST;
      slow_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      slow_q <= (cnt_nxt < CW'(HALF));
    end
  end

  assign slow_clk = slow_q;

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  assert_rise_at_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_q) |-> (cnt_q == '0));
endmodule

// File: rtl/gbx_load_align.sv
module gbx_load_align (
  input  logic clk,
  input  logic rst,
  input  logic slow_clk,
  output logic cap_en,
  output logic load
);
  logic slow_d, load_q;

  // cap_en: first fast cycle after a slow rise; load: the cycle after that.
  always_comb cap_en = slow_clk & ~slow_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_d <= 1'b0;
      load_q <= 1'b0;
    end else begin
      slow_d <= slow_clk;
      load_q <= cap_en;
    end
  end

  assign load = load_q;

  assert_load_single_R3: assert property (@(posedge clk) disable iff (rst)
    load_q |=> !load_q);
  assert_cap_then_load_R3: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> load_q);
endmodule

// File: rtl/gbx_sync_reg.sv
module gbx_sync_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)         q_r <= '0;
    else if (cap_en) q_r <= d;
  end

  assign q = q_r;

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(q_r));
endmodule

// File: rtl/gbx_shift_out.sv
module gbx_shift_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         ser,
  output logic         ws
);
  localparam int CW = gbx_pkg::cnt_bits(W);

  logic [W-1:0] sh_q;
  logic ws_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      ws_q <= 1'b0;
    end else begin
      ws_q <= load;
      if (load) sh_q <= d;
      else      sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign ser = sh_q[W-1];
  assign ws  = ws_q;

  // Checker: loads must arrive exactly W cycles apart once streaming.
  logic [CW-1:0] gap_q;
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (load) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    (load && seen_q) |-> (gap_q == CW'(W - 1)));
  assert_shift_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> (sh_q == {$past(sh_q[W-2:0]), 1'b0}));
  assert_ws_after_load_R6: assert property (@(posedge clk) disable iff (rst)
    ws_q |-> $past(load));
endmodule

// File: rtl/gearbox_serializer.sv
module gearbox_serializer #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] par_data,
  output logic              slow_clk,
  output logic              ser_out,
  output logic              word_start
);
  logic cap_en, load;
  logic [WORD_W-1:0] held;

  gbx_clk_div #(.N(WORD_W)) u_div (
    .clk(clk), .rst(rst), .slow_clk(slow_clk)
  );

  gbx_load_align u_align (
    .clk(clk), .rst(rst), .slow_clk(slow_clk), .cap_en(cap_en), .load(load)
  );

  gbx_sync_reg #(.W(WORD_W)) u_hold (
    .clk(clk), .rst(rst), .cap_en(cap_en), .d(par_data), .q(held)
  );

  gbx_shift_out #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .d(held), .ser(ser_out), .ws(word_start)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (!ser_out && !word_start && !slow_clk));
endmodule

// File: tb/gearbox_serializer_bench.sv
module gearbox_serializer_bench;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] par_data = '0;
  logic slow_clk, ser_out, word_start;

  int n_run = 0;
  int n_fail = 0;

  gearbox_serializer #(.WORD_W(W)) u_gearbox_serializer (
    .clk(clk), .rst(rst), .par_data(par_data),
    .slow_clk(slow_clk), .ser_out(ser_out), .word_start(word_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // R9 and R2: quiet outputs during reset, slow clock rises on first edge after release.
  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 ser_out in reset", ser_out, 0);
    check("R9 word_start in reset", word_start, 0);
    check("R9 slow_clk in reset", slow_clk, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 slow_clk high after first edge", slow_clk, 1);
  endtask

  // R1: period and high time of the divided clock.
  task automatic t_divider();
    int high = 0;
    @(posedge slow_clk);
    for (int m = 0; m < W; m++) begin
      @(negedge clk);
      if (m == W - 1) check("R1 slow_clk low before wrap", slow_clk, 0);
      if (slow_clk) high++;
    end
    check("R1 slow_clk high cycles", high, W / 2);
    @(negedge clk);
    check("R1 slow_clk rises after W cycles", slow_clk, 1);
  endtask

  // R3..R8: present words on each slow rise and rebuild them from ser_out.
  // At negedge m after the aligning rise: word i driven at m=i*W,
  // bit b of word i read at m = 2 + i*W + b.
  task automatic t_stream(input string name, input logic [W-1:0] w [4], input bit disturb);
    logic [W-1:0] got [4];
    int ws_err [4];
    for (int i = 0; i < 4; i++) begin got[i] = '0; ws_err[i] = 0; end
    @(posedge slow_clk);
    for (int m = 0; m < 4 * W + 2; m++) begin
      @(negedge clk);
      if (m >= 2) begin
        int i = (m - 2) / W;
        int b = (m - 2) % W;
        got[i][W-1-b] = ser_out;
        if (word_start !== (b == 0)) ws_err[i]++;
      end
      if ((m % W == 0) && (m / W < 4)) par_data = w[m / W];
      else if (disturb && (m % W == 1) && (m / W < 4)) par_data = ~w[m / W];
    end
    for (int i = 0; i < 4; i++) begin
      if (disturb) check({"R8 late change ignored ", name}, got[i], w[i]);
      else check({"R4 R5 R7 word ", name}, got[i], w[i]);
      check({"R3 R6 word_start ", name}, ws_err[i], 0);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin : main
    logic [W-1:0] p_alt [4];
    logic [W-1:0] p_edge [4];
    logic [W-1:0] p_cnt [4];
    p_alt  = '{8'hAA, 8'h55, 8'hAA, 8'h55};
    p_edge = '{8'hFF, 8'h00, 8'h01, 8'h80};
    p_cnt  = '{8'h3C, 8'h3D, 8'h3E, 8'h3F};
    repeat (2) @(negedge clk);
    t_reset();
    t_divider();
    t_stream("alternating", p_alt, 1'b0);
    t_stream("solid/walking", p_edge, 1'b0);
    t_stream("counting", p_cnt, 1'b0);
    t_stream("disturbed", p_cnt, 1'b1);
    t_reset();
    t_stream("after reset", p_edge, 1'b0);
    report();
  end
endmodule